// File: doc/BRIEF.md
# Macro Engine Arithmetic Logic Unit

This block is the execute stage of a small 32-bit macro processor. Each cycle it decodes one instruction word against two source operands that the register file has already read. It returns a 32-bit result. The datapath is combinational: a result belongs to the instruction presented in the same cycle. The only state is a carry flip-flop, which chained additions and subtractions use.

The operation class is taken from the three low bits of the instruction. Class 0 runs a register-register function: add or subtract, with or without the carry, or one of five bitwise functions. Class 1 adds a signed immediate to operand A. Classes 2, 3 and 4 insert or extract bitfields using packed position and size fields. Class 5 reads an external state register at A plus the immediate. The read uses a same-cycle request and response port, and the returned word becomes the result.

Class 7 is a branch and is handled outside this block. Class 6 and any unassigned register function raise an illegal-instruction flag.

Top module: `macro_alu`

## Requirements
- R1: `op = instr_i[2:0]`. For op 7 (branch) the block gives `result_o` = 0, raises no illegal flag, issues no read, and leaves the carry unchanged.
- R2: With op 0, `fn = instr_i[21:17]`. For fn 0 the result is A+B and fn 1 gives A+B+carry. Both set the carry to bit 32 of the unsigned sum.
- R3: With op 0, fn 2 gives A−B and sets the carry to 1 when A ≥ B (no borrow). Fn 3 gives A−B−(1−carry) and sets the carry to 1 when no borrow occurs.
- R4: With op 0, the bitwise functions are fn 8 A XOR B, fn 9 A OR B, fn 10 A AND B, fn 11 A AND NOT B, and fn 12 NOT(A AND B).
- R5: The immediate is `instr_i[31:14]` sign-extended to 32 bits. Op 1 gives A + immediate.
- R6: Let `s = instr_i[21:17]`, `n = instr_i[26:22]`, `d = instr_i[31:27]` and `mask = (1<<n)−1`. Op 2 gives `(A & ~(mask<<d)) | (((B>>s)&mask)<<d)`, where all shifts are logical.
- R7: Op 3 gives `((B >> A[4:0]) & mask) << d`.
- R8: Op 4 gives `((B >> s) & mask) << A[4:0]`.
- R9: Op 5 with `valid_i` high sets `rd_req_o`, drives `rd_addr_o` = A + immediate, and gives `result_o` = `rd_data_i`. No other case sets `rd_req_o`.
- R10: With `valid_i` high, op 6 and any op-0 function code outside {0,1,2,3,8..12} set `illegal_o`, give a result of 0, and leave the carry unchanged.
- R11: The carry resets to 0. It changes only at a clock edge where `valid_i` is high and the instruction is op 0 with fn 0 to 3.
- R12: A size field of 0 gives a zero mask. A shift amount taken from A uses only A[4:0], so higher bits of A have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction strobe for this cycle |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 32 | Operand A value |
| src_b_i | input | 32 | Operand B value |
| rd_data_i | input | 32 | Read response for the external register |
| rd_req_o | output | 1 | External register read request |
| rd_addr_o | output | 32 | External register read address |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Carry flag |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The assertions assume that `instr_i`, `src_a_i`, `src_b_i` and `valid_i` are stable and known from the negative edge through the following rising edge. They also assume that `rd_data_i` responds within the same cycle as a read request. The stimulus drives every input only at the falling edge and holds it through the next rising edge. It also supplies a defined read-response word on every cycle, including cycles that issue no read, so the assumptions hold throughout. The carry history is built up on purpose: an overflowing add precedes the strobe-low and illegal cases, so that a wrongly applied update would show up as a changed flag.

// File: rtl/macro_alu_pkg.sv
`timescale 1ns/1ps
package macro_alu_pkg;
    localparam int WORD_W  = 32;
    localparam int SEL_W   = 5;
    localparam int IMM_LSB = 14;
    localparam int IMM_W   = WORD_W - IMM_LSB;

    typedef enum logic [2:0] {
        OP_REG    = 3'd0,
        OP_ADDI   = 3'd1,
        OP_BF_INS = 3'd2,
        OP_BF_XI  = 3'd3,
        OP_BF_XR  = 3'd4,
        OP_RDI    = 3'd5,
        OP_RSV    = 3'd6,
        OP_BRANCH = 3'd7
    } op_e;

    typedef enum logic [SEL_W-1:0] {
        FN_ADD  = 5'd0,
        FN_ADC  = 5'd1,
        FN_SUB  = 5'd2,
        FN_SBB  = 5'd3,
        FN_XOR  = 5'd8,
        FN_OR   = 5'd9,
        FN_AND  = 5'd10,
        FN_ANDN = 5'd11,
        FN_NAND = 5'd12
    } fn_e;

    typedef struct packed {
        op_e               op;
        logic [SEL_W-1:0]  fn;
        logic [SEL_W-1:0]  bf_src;
        logic [SEL_W-1:0]  bf_size;
        logic [SEL_W-1:0]  bf_dst;
        logic [WORD_W-1:0] imm;
        logic              is_arith;
        logic              illegal;
    } dec_t;

    function automatic logic fn_known(input logic [SEL_W-1:0] fn);
        return (fn <= FN_SBB) || ((fn >= FN_XOR) && (fn <= FN_NAND));
    endfunction

    function automatic logic [WORD_W-1:0] field_mask(input logic [SEL_W-1:0] size);
        return ~({WORD_W{1'b1}} << size);
    endfunction
endpackage

// File: rtl/macro_alu_decode.sv
`timescale 1ns/1ps
module macro_alu_decode
    import macro_alu_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output dec_t              dec_o
);
    logic unused_fields;
    assign unused_fields = ^instr_i[IMM_LSB-1:3];

    always_comb begin
        dec_o.op       = op_e'(instr_i[2:0]);
        dec_o.fn       = instr_i[21:17];
        dec_o.bf_src   = instr_i[21:17];
        dec_o.bf_size  = instr_i[26:22];
        dec_o.bf_dst   = instr_i[31:27];
        dec_o.imm      = {{(WORD_W-IMM_W){instr_i[WORD_W-1]}}, instr_i[WORD_W-1:IMM_LSB]};
        dec_o.is_arith = (dec_o.op == OP_REG) && (dec_o.fn <= FN_SBB);
        dec_o.illegal  = (dec_o.op == OP_RSV) ||
                         ((dec_o.op == OP_REG) && !fn_known(dec_o.fn));
    end
endmodule

// File: rtl/macro_alu_regop.sv
`timescale 1ns/1ps
module macro_alu_regop
    import macro_alu_pkg::*;
(
    input  logic [SEL_W-1:0]  fn_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              carry_i,
    output logic [WORD_W-1:0] res_o,
    output logic              carry_o
);
    logic              subtract;
    logic              cin;
    logic [WORD_W:0]   sum;

    // Subtraction is A + ~B + cin; the carry out then means "no borrow".
    assign subtract = fn_i[1];
    assign cin      = fn_i[0] ? carry_i : subtract;
    assign sum      = {1'b0, a_i} + {1'b0, (subtract ? ~b_i : b_i)} + {{WORD_W{1'b0}}, cin};
    assign carry_o  = sum[WORD_W];

    always_comb begin
        unique case (fn_i)
            FN_ADD, FN_ADC, FN_SUB, FN_SBB: res_o = sum[WORD_W-1:0];
            FN_XOR:  res_o = a_i ^ b_i;
            FN_OR:   res_o = a_i | b_i;
            FN_AND:  res_o = a_i & b_i;
            FN_ANDN: res_o = a_i & ~b_i;
            FN_NAND: res_o = ~(a_i & b_i);
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/macro_alu_bitfield.sv
`timescale 1ns/1ps
module macro_alu_bitfield
    import macro_alu_pkg::*;
(
    input  op_e               op_i,
    input  logic [SEL_W-1:0]  src_i,
    input  logic [SEL_W-1:0]  size_i,
    input  logic [SEL_W-1:0]  dst_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] res_o
);
    logic [WORD_W-1:0] mask;
    logic [SEL_W-1:0]  sh_a;
    logic [WORD_W-1:0] fixed_field;
    logic [WORD_W-1:0] var_field;

    assign mask        = field_mask(size_i);
    assign sh_a        = a_i[SEL_W-1:0];
    assign fixed_field = (b_i >> src_i) & mask;
    assign var_field   = (b_i >> sh_a) & mask;

    always_comb begin
        unique case (op_i)
            OP_BF_INS: res_o = (a_i & ~(mask << dst_i)) | (fixed_field << dst_i);
            OP_BF_XI:  res_o = var_field << dst_i;
            OP_BF_XR:  res_o = fixed_field << sh_a;
            default:   res_o = '0;
        endcase
    end
endmodule

// File: rtl/macro_alu_carry.sv
`timescale 1ns/1ps
module macro_alu_carry (
    input  logic clk,
    input  logic rst,
    input  logic upd_i,
    input  logic nxt_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (upd_i) q_o <= nxt_i;
    end
endmodule

// File: rtl/macro_alu.sv
`timescale 1ns/1ps
module macro_alu
    import macro_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] src_a_i,
    input  logic [WORD_W-1:0] src_b_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              rd_req_o,
    output logic [WORD_W-1:0] rd_addr_o,
    output logic [WORD_W-1:0] result_o,
    output logic              carry_o,
    output logic              illegal_o
);
    dec_t              dec;
    logic [WORD_W-1:0] reg_res;
    logic [WORD_W-1:0] bf_res;
    logic [WORD_W-1:0] a_plus_imm;
    logic              carry_nxt;

    macro_alu_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    macro_alu_regop u_reg (
        .fn_i    (dec.fn),
        .a_i     (src_a_i),
        .b_i     (src_b_i),
        .carry_i (carry_o),
        .res_o   (reg_res),
        .carry_o (carry_nxt)
    );

    macro_alu_bitfield u_bf (
        .op_i   (dec.op),
        .src_i  (dec.bf_src),
        .size_i (dec.bf_size),
        .dst_i  (dec.bf_dst),
        .a_i    (src_a_i),
        .b_i    (src_b_i),
        .res_o  (bf_res)
    );

    macro_alu_carry u_carry (
        .clk   (clk),
        .rst   (rst),
        .upd_i (valid_i && dec.is_arith),
        .nxt_i (carry_nxt),
        .q_o   (carry_o)
    );

    assign a_plus_imm = src_a_i + dec.imm;
    assign rd_addr_o  = a_plus_imm;
    assign rd_req_o   = valid_i && (dec.op == OP_RDI);
    assign illegal_o  = valid_i && dec.illegal;

    always_comb begin
        unique case (dec.op)
            OP_REG:                      result_o = reg_res;
            OP_ADDI:                     result_o = a_plus_imm;
            OP_BF_INS, OP_BF_XI, OP_BF_XR: result_o = bf_res;
            OP_RDI:                      result_o = rd_data_i;
            default:                     result_o = '0;
        endcase
    end
endmodule

// File: rtl/macro_alu_chk.sv
`timescale 1ns/1ps
module macro_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [31:0] instr_i,
    input logic [31:0] src_a_i,
    input logic [31:0] src_b_i,
    input logic [31:0] rd_data_i,
    input logic        rd_req_o,
    input logic [31:0] rd_addr_o,
    input logic [31:0] result_o,
    input logic        carry_o,
    input logic        illegal_o
);
    logic [31:0] imm_sx;
    logic        carry_strobe;
    assign imm_sx       = {{14{instr_i[31]}}, instr_i[31:14]};
    assign carry_strobe = valid_i && (instr_i[2:0] == 3'd0) && (instr_i[21:19] == 3'd0);

    // R11
    carry_reset_chk: assert property (@(posedge clk) rst |=> !carry_o);

    // R11
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !carry_strobe |=> $stable(carry_o));

    // R10
    rsv_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i[2:0] == 3'd6) |-> (illegal_o && result_o == 32'd0));

    // R1
    branch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i[2:0] == 3'd7) |-> (!illegal_o && !rd_req_o && result_o == 32'd0));

    // R9
    read_addr_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |-> (valid_i && instr_i[2:0] == 3'd5 &&
                      rd_addr_o == src_a_i + imm_sx && result_o == rd_data_i));

    // R4
    xor_result_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_i[2:0] == 3'd0 && instr_i[21:17] == 5'd8) |-> result_o == (src_a_i ^ src_b_i));

    // R2
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i[2:0] == 3'd0 && instr_i[21:17] == 5'd0) |=>
        carry_o == $past((33'(src_a_i) + 33'(src_b_i)) > 33'h0FFFF_FFFF));

    // R3
    sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i[2:0] == 3'd0 && instr_i[21:17] == 5'd2) |=>
        carry_o == $past(src_a_i >= src_b_i));
endmodule

bind macro_alu macro_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .src_a_i   (src_a_i),
    .src_b_i   (src_b_i),
    .rd_data_i (rd_data_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .illegal_o (illegal_o)
);

// File: tb/macro_alu_bench.sv
`timescale 1ns/1ps
module macro_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [31:0] rd_data_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic [31:0] result_o;
    logic        carry_o;
    logic        illegal_o;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_c = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    macro_alu u_macro_alu (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .rd_data_i(rd_data_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .result_o(result_o),
        .carry_o(carry_o), .illegal_o(illegal_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] rdd, input logic v);
        logic [63:0] wa, wb, mask, r;
        logic [31:0] imm;
        logic [4:0]  s, n, d;
        logic        ill, upd, nc;
        wa = {32'd0, a}; wb = {32'd0, b};
        imm = 32'($signed(ins) >>> 14);
        s = ins[21:17]; n = ins[26:22]; d = ins[31:27];
        mask = (64'd1 << n) - 64'd1;
        ill = 1'b0; upd = 1'b0; nc = exp_c; r = '0;
        case (ins[2:0])
            3'd0: case (ins[21:17])
                5'd0:  begin r = wa + wb; nc = r > 64'hFFFF_FFFF; upd = 1'b1; end
                5'd1:  begin r = wa + wb + 64'(exp_c); nc = r > 64'hFFFF_FFFF; upd = 1'b1; end
                5'd2:  begin r = wa - wb; nc = wa >= wb; upd = 1'b1; end
                5'd3:  begin r = wa - wb - 64'(!exp_c); nc = wa >= wb + 64'(!exp_c); upd = 1'b1; end
                5'd8:  r = wa ^ wb;
                5'd9:  r = wa | wb;
                5'd10: r = wa & wb;
                5'd11: r = wa & ~wb;
                5'd12: r = ~(wa & wb);
                default: ill = 1'b1;
            endcase
            3'd1: r = 64'(a + imm);
            3'd2: r = (wa & ~(mask << d)) | (((wb >> s) & mask) << d);
            3'd3: r = ((wb >> a[4:0]) & mask) << d;
            3'd4: r = ((wb >> s) & mask) << a[4:0];
            3'd5: r = {32'd0, rdd};
            3'd6: ill = 1'b1;
            default: r = '0;
        endcase
        @(negedge clk);
        valid_i = v; instr_i = ins; src_a_i = a; src_b_i = b; rd_data_i = rdd;
        #1;
        check({req, " result"}, result_o, r[31:0]);
        check({req, " illegal"}, {31'd0, illegal_o}, {31'd0, v && ill});
        check({req, " read request"}, {31'd0, rd_req_o}, {31'd0, v && ins[2:0] == 3'd5});
        if (ins[2:0] == 3'd5) check({req, " read address"}, rd_addr_o, a + imm);
        @(posedge clk); #1;
        if (v && upd && !ill) exp_c = nc;
        check({req, " carry"}, {31'd0, carry_o}, {31'd0, exp_c});
    endtask

    function automatic logic [31:0] reg_ins(input logic [4:0] fn);
        return {10'd0, fn, 3'd5, 3'd2, 3'd1, 5'd0, 3'd0};
    endfunction

    function automatic logic [31:0] bf_ins(input logic [2:0] op, input logic [4:0] s,
                                           input logic [4:0] n, input logic [4:0] d);
        return {d, n, s, 14'd0, op};
    endfunction

    logic [31:0] va [8] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                            32'h1, 32'hDEAD_BEEF, 32'h1234_5678, 32'hFFFF_FFFE};
    logic [4:0]  bits [3] = '{5'd0, 5'd7, 5'd31};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R11 reset state
        check("R11 reset carry", {31'd0, carry_o}, 32'd0);
        check("R9 reset request", {31'd0, rd_req_o}, 32'd0);
        check("R10 reset illegal", {31'd0, illegal_o}, 32'd0);

        for (int f = 0; f < 16; f++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    string tag;
                    tag = (f < 2) ? "R2" : (f < 4) ? "R3" :
                          (f >= 8 && f <= 12) ? "R4" : "R10";
                    step(tag, reg_ins(5'(f)), va[i], va[j], 32'h5A5A_0000, 1'b1);
                end
            end
        end

        for (int k = 0; k < 18; k++) begin
            step("R5 positive", {18'(1) << k, 11'd0, 3'd1}, va[k % 8], 32'd0, 32'd0, 1'b1);
            step("R5 negative", {~(18'(1) << k), 11'd0, 3'd1}, va[(k + 3) % 8], 32'd0, 32'd0, 1'b1);
        end

        for (int op = 2; op <= 4; op++) begin
            for (int n = 0; n < 32; n++) begin
                for (int si = 0; si < 3; si++) begin
                    for (int di = 0; di < 3; di++) begin
                        string tag;
                        logic [31:0] a;
                        a = (op == 2) ? 32'hA5A5_5A5A : (32'h1357_9BE0 | 32'((n + si * 11 + di * 5) % 32));
                        tag = (n == 0) ? "R12 zero size" : (op == 2) ? "R6" : (op == 3) ? "R7" : "R8";
                        step(tag, bf_ins(3'(op), bits[si], 5'(n), bits[di]), a, 32'hC3A5_96F1, 32'd0, 1'b1);
                    end
                end
            end
        end

        // R12 high bits of A ignored as shift amount
        step("R12 high A bits", bf_ins(3'd3, 5'd0, 5'd8, 5'd0), 32'hFFFF_FFE4, 32'h0000_AB00, 32'd0, 1'b1);
        step("R12 high A bits", bf_ins(3'd4, 5'd0, 5'd4, 5'd0), 32'h8000_0024, 32'h0000_000F, 32'd0, 1'b1);

        for (int k = 0; k < 8; k++) begin
            step("R9 read", {18'(k * 4099) ^ 18'h20000, 11'd0, 3'd5}, va[k], 32'd0, va[7 - k] ^ 32'h0F0F_0F0F, 1'b1);
        end
        step("R9 read without strobe", {18'd4, 11'd0, 3'd5}, 32'h100, 32'd0, 32'hCAFE_F00D, 1'b0);

        // R11: set carry, then attempt updates that must not apply
        step("R2 set carry", reg_ins(5'd0), 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1);
        step("R11 strobe low", reg_ins(5'd2), 32'd0, 32'd1, 32'd0, 1'b0);
        step("R10 reserved op", 32'h0000_0006, 32'd0, 32'd1, 32'd0, 1'b1);
        step("R10 bad function", reg_ins(5'd31), 32'd0, 32'd1, 32'd0, 1'b1);
        step("R1 branch", 32'hFFFF_C017, 32'h1, 32'h2, 32'h3, 1'b1);
        step("R11 non-arith op", 32'h0004_0001, 32'd0, 32'd0, 32'd0, 1'b1);
        step("R3 clear carry", reg_ins(5'd2), 32'd0, 32'd1, 32'd0, 1'b1);

        @(negedge clk); valid_i = 1'b0;
        @(posedge clk); @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R11 reset clears", {31'd0, carry_o}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule